// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block brings an SD card from power-up to a usable state in SPI mode. It does not shift bits itself. It hands each step to an external command engine: a run of idle clocks, or one command with its argument. It then reads back the R1 byte and the 32 trailing response bits that the engine collected. It also owns the card's chip select. Chip select is high during the wake-up clocks and between ordinary commands. It stays low for the whole operating-condition polling loop.

The steps run in a fixed order:
- a reset command with a bounded number of retries;
- an interface-condition check with an echo pattern;
- a polled application-command pair, repeated until the card reports it has left idle;
- a read of the operating-conditions register, which gives the addressing mode;
- a block-length command that sets 512 bytes.

A single cycle budget, captured from an input when the sequence starts, bounds the whole run. Software loads that input with one second's worth of system clocks, so the wait does not depend on the clock frequency. A card that never answers the reset command is rejected after the retries, with no wait for the long budget.

On completion the block raises `ready` and reports whether the card uses block addressing. Otherwise it reports a nonzero failure code that names the phase that failed.

Top module: `sd_spi_init_seq`

## Requirements
- R1: After `start` is accepted, the first engine operation is an idle-clock operation (`eng_op`=1) with `eng_arg` = INIT_CLKS (at least 74) and `cs_n` high. The second operation is command index 0 with argument 0.
- R2: The reset command (index 0) passes only on R1 = 0x01. Any other R1 reissues it, up to CMD0_TRIES (10) attempts in total. A failed tenth attempt ends the run at once with `fail_code` = 1.
- R3: Command index 8 is sent with argument 0x000001AA. It passes when R1 = 0x01 and response bits [11:0] = 0x1AA. Otherwise the run ends with `fail_code` = 2.
- R4: Command index 55 (R1 must be 0x01) is followed by index 41 with argument 0x40000000. On index 41, R1 = 0x00 moves on, R1 = 0x01 repeats the pair, and any other value ends the run with `fail_code` = 3. A bad R1 to index 55 also ends the run with `fail_code` = 3.
- R5: Command index 58 (argument 0) must return R1 = 0x00, or the run ends with `fail_code` = 4. Response bit 30 is reported as `block_addr`.
- R6: Command index 16 is sent with argument 0x00000200 and must return R1 = 0x00. Success raises `ready`. Any other R1 ends the run with `fail_code` = 4.
- R7: `timeout_cycles` is captured when `start` is accepted. If the run has not ended after that many clocks, it stops with `busy` low one clock later, i.e. T+1 clocks after the start edge. The code then names the phase: 1 for wake-up or reset, 2 for the interface check, 3 for the polling loop, 4 for the register read or block length.
- R8: `cs_n` is low whenever a command is outstanding. It is high for at least the one cycle before each request of index 0, 8, 58 and 16. It is low continuously through the 55/41 loop.
- R9: After reset, `ready`, `fail_code`, `busy` and `eng_req` are 0 and `cs_n` is 1. While busy, `ready` and `fail_code` read 0. `block_addr` reads 0 unless `ready`. A new `start` after an ending clears the outcome.
- R10: `eng_req` is a single-cycle pulse per operation, never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken when not busy) |
| timeout_cycles | input | 32 | Cycle budget for the whole sequence |
| cs_n | output | 1 | Card chip select, active low |
| eng_req | output | 1 | One-cycle request to the command engine |
| eng_op | output | 1 | 1 = send idle clocks, 0 = send a command |
| eng_cmd | output | 6 | Command index |
| eng_arg | output | 32 | Command argument, or idle clock count |
| eng_done | input | 1 | Engine finished the current operation |
| eng_r1 | input | 8 | R1 byte returned by the card |
| eng_resp | input | 32 | Trailing 32 response bits (R3/R7) |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Card initialized |
| block_addr | output | 1 | Card uses block addressing (valid with ready) |
| fail_code | output | 3 | 0 none, 1 no reset reply, 2 bad echo, 3 polling failure, 4 setup error |

## Verification
The bench builds the block with its default parameters: 80 wake-up clocks and ten reset attempts. The ten-attempt limit is reached in a few dozen cycles, both on its last try and one step past it. The budget is an input, so each scenario can feed a small value (50, 300 or 600 cycles). This brings expiry in the reset, interface-check and polling phases into reach within a short run. It also lets the exact expiry cycle be measured against the captured count.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAKE, ST_CMD0, ST_CMD8, ST_CMD55,
        ST_ACMD41, ST_CMD58, ST_CMD16, ST_DONE, ST_FAIL
    } seq_state_e;

    localparam logic [2:0] FAIL_NONE   = 3'd0;
    localparam logic [2:0] FAIL_NOCARD = 3'd1;
    localparam logic [2:0] FAIL_IFCOND = 3'd2;
    localparam logic [2:0] FAIL_OPCOND = 3'd3;
    localparam logic [2:0] FAIL_SETUP  = 3'd4;

    localparam logic [7:0]  R1_IDLE    = 8'h01;
    localparam logic [7:0]  R1_READY   = 8'h00;
    localparam logic [31:0] ARG_IFCOND = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS    = 32'h4000_0000;
    localparam logic [31:0] ARG_BLKLEN = 32'h0000_0200;

    typedef struct packed {
        seq_state_e state;
        logic       issued;
        logic       req;
        logic       blk;
        logic       ready;
        logic [2:0] fail;
    } seq_regs_t;

    function automatic logic [5:0] cmd_of(seq_state_e s);
        case (s)
            ST_CMD8:   return 6'd8;
            ST_CMD55:  return 6'd55;
            ST_ACMD41: return 6'd41;
            ST_CMD58:  return 6'd58;
            ST_CMD16:  return 6'd16;
            default:   return 6'd0;
        endcase
    endfunction

    function automatic logic [2:0] phase_fail(seq_state_e s);
        case (s)
            ST_WAKE, ST_CMD0:    return FAIL_NOCARD;
            ST_CMD8:             return FAIL_IFCOND;
            ST_CMD55, ST_ACMD41: return FAIL_OPCOND;
            default:             return FAIL_SETUP;
        endcase
    endfunction

endpackage

// File: rtl/sdinit_timeout.sv
module sdinit_timeout #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit,
    input  logic          run,
    output logic          expired
);
    logic [TW-1:0] count_d, count_q;

    always_comb begin
        if (load)
            count_d = limit;
        else if (run && count_q != '0)
            count_d = count_q - 1'b1;
        else
            count_d = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = run && !load && (count_q == '0);

    // R7: a freshly loaded budget is never consumed in the same cycle
    a_r7_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired || ($past(limit) == '0));
endmodule

// File: rtl/sdinit_tries.sv
module sdinit_tries #(
    parameter int TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(TRIES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)
            cnt_d = '0;
        else if (bump && cnt_q != CW'(TRIES))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(TRIES - 1));

    // R2: the attempt count never runs past the configured limit
    a_r2_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TRIES));
endmodule

// File: rtl/sdinit_resp_check.sv
module sdinit_resp_check
    import sdinit_pkg::*;
(
    input  seq_state_e  state,
    input  logic [7:0]  r1,
    input  logic [31:0] resp,
    output logic        ok
);
    logic unused_resp_bits;
    assign unused_resp_bits = ^resp[31:12];

    always_comb begin
        case (state)
            ST_WAKE:   ok = 1'b1;
            ST_CMD0:   ok = (r1 == R1_IDLE);
            ST_CMD8:   ok = (r1 == R1_IDLE) && (resp[11:0] == ARG_IFCOND[11:0]);
            ST_CMD55:  ok = (r1 == R1_IDLE);
            ST_ACMD41,
            ST_CMD58,
            ST_CMD16:  ok = (r1 == R1_READY);
            default:   ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd_spi_init_seq.sv
module sd_spi_init_seq
    import sdinit_pkg::*;
#(
    parameter int INIT_CLKS  = 80,
    parameter int CMD0_TRIES = 10,
    parameter int TW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] timeout_cycles,
    output logic          cs_n,
    output logic          eng_req,
    output logic          eng_op,
    output logic [5:0]    eng_cmd,
    output logic [31:0]   eng_arg,
    input  logic          eng_done,
    input  logic [7:0]    eng_r1,
    input  logic [31:0]   eng_resp,
    output logic          busy,
    output logic          ready,
    output logic          block_addr,
    output logic [2:0]    fail_code
);
    localparam logic [31:0] WAKE_ARG = 32'(INIT_CLKS);

    seq_regs_t q, d;
    logic      resp_ok, expired, tries_last, take_start, cmd0_miss;

    assign busy       = !(q.state inside {ST_IDLE, ST_DONE, ST_FAIL});
    assign take_start = start && !busy;
    assign cmd0_miss  = (q.state == ST_CMD0) && q.issued && eng_done && !expired && !resp_ok;

    sdinit_resp_check u_check (
        .state (q.state),
        .r1    (eng_r1),
        .resp  (eng_resp),
        .ok    (resp_ok)
    );

    sdinit_timeout #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_start),
        .limit   (timeout_cycles),
        .run     (busy),
        .expired (expired)
    );

    sdinit_tries #(.TRIES(CMD0_TRIES)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take_start),
        .bump  (cmd0_miss),
        .last  (tries_last)
    );

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (!busy) begin
            if (start) begin
                d.state  = ST_WAKE;
                d.issued = 1'b0;
                d.ready  = 1'b0;
                d.blk    = 1'b0;
                d.fail   = FAIL_NONE;
            end
        end else if (expired) begin
            d.state  = ST_FAIL;
            d.issued = 1'b0;
            d.fail   = phase_fail(q.state);
        end else if (!q.issued) begin
            d.req    = 1'b1;
            d.issued = 1'b1;
        end else if (eng_done) begin
            d.issued = 1'b0;
            case (q.state)
                ST_WAKE: d.state = ST_CMD0;
                ST_CMD0: begin
                    if (resp_ok)         d.state = ST_CMD8;
                    else if (tries_last) begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_NOCARD;
                    end
                end
                ST_CMD8: begin
                    if (resp_ok) d.state = ST_CMD55;
                    else begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_IFCOND;
                    end
                end
                ST_CMD55: begin
                    if (resp_ok) d.state = ST_ACMD41;
                    else begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_OPCOND;
                    end
                end
                ST_ACMD41: begin
                    if (resp_ok)                d.state = ST_CMD58;
                    else if (eng_r1 == R1_IDLE) d.state = ST_CMD55;
                    else begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_OPCOND;
                    end
                end
                ST_CMD58: begin
                    if (resp_ok) begin
                        d.state = ST_CMD16;
                        d.blk   = eng_resp[30];
                    end else begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_SETUP;
                    end
                end
                ST_CMD16: begin
                    if (resp_ok) begin
                        d.state = ST_DONE;
                        d.ready = 1'b1;
                    end else begin
                        d.state = ST_FAIL;
                        d.fail  = FAIL_SETUP;
                    end
                end
                default: d.state = ST_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.issued <= 1'b0;
            q.req    <= 1'b0;
            q.blk    <= 1'b0;
            q.ready  <= 1'b0;
            q.fail   <= FAIL_NONE;
        end else begin
            q <= d;
        end
    end

    assign cs_n = !((q.state inside {ST_CMD55, ST_ACMD41}) ||
                    (q.issued && (q.state inside {ST_CMD0, ST_CMD8, ST_CMD58, ST_CMD16})));

    assign eng_req    = q.req;
    assign eng_op     = (q.state == ST_WAKE);
    assign eng_cmd    = cmd_of(q.state);
    assign ready      = q.ready;
    assign fail_code  = q.fail;
    assign block_addr = q.blk && q.ready;

    always_comb begin
        case (q.state)
            ST_WAKE:   eng_arg = WAKE_ARG;
            ST_CMD8:   eng_arg = ARG_IFCOND;
            ST_ACMD41: eng_arg = ARG_HCS;
            ST_CMD16:  eng_arg = ARG_BLKLEN;
            default:   eng_arg = '0;
        endcase
    end

    // R2: a miss on the last reset attempt ends the run with the no-card code
    a_r2_fast_nocard: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd0_miss && tries_last) |=> (fail_code == FAIL_NOCARD) && !busy);

    // R4: a ready reply to the polled command moves on to the register read
    a_r4_leave_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ACMD41 && q.issued && eng_done && !expired && eng_r1 == R1_READY)
        |=> (q.state == ST_CMD58));

    // R7: budget expiry during a run always leaves a failure code
    a_r7_expiry_reported: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !busy && (fail_code != FAIL_NONE));

    // R8: a command request is never made with the card deselected
    a_r8_selected_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_op) |-> !cs_n);

    // R9: success and failure never show together, and never while busy
    a_r9_clean_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (fail_code == FAIL_NONE) && !busy);

    // R10: one request pulse per operation
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
endmodule

// File: tb/sd_spi_init_seq_test.sv
`timescale 1ns/1ps
module sd_spi_init_seq_test;

    typedef struct packed {
        logic [3:0]  bad0;    // leading bad reset replies (15 = always bad)
        logic        echo_ok;
        logic [7:0]  busy41;  // polled replies still idle (255 = forever)
        logic        ccs;
        logic        bad58;
        logic        bad16;
        logic [5:0]  stall;   // command index never answered (63 = none)
        logic [31:0] tmo;
        logic [2:0]  e_fail;
        logic        e_ready;
        logic        e_blk;
        logic [7:0]  e_cmd0;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 8'd3,   1'b1, 1'b0, 1'b0, 6'd63, 32'd100000, 3'd0, 1'b1, 1'b1, 8'd1},
        '{4'd2,  1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 6'd63, 32'd100000, 3'd0, 1'b1, 1'b0, 8'd3},
        '{4'd9,  1'b1, 8'd1,   1'b1, 1'b0, 1'b0, 6'd63, 32'd100000, 3'd0, 1'b1, 1'b1, 8'd10},
        '{4'd15, 1'b1, 8'd0,   1'b1, 1'b0, 1'b0, 6'd63, 32'd100000, 3'd1, 1'b0, 1'b0, 8'd10},
        '{4'd0,  1'b0, 8'd0,   1'b1, 1'b0, 1'b0, 6'd63, 32'd100000, 3'd2, 1'b0, 1'b0, 8'd1},
        '{4'd0,  1'b1, 8'd255, 1'b1, 1'b0, 1'b0, 6'd63, 32'd600,    3'd3, 1'b0, 1'b0, 8'd1},
        '{4'd0,  1'b1, 8'd2,   1'b1, 1'b1, 1'b0, 6'd63, 32'd100000, 3'd4, 1'b0, 1'b0, 8'd1},
        '{4'd0,  1'b1, 8'd2,   1'b1, 1'b0, 1'b1, 6'd63, 32'd100000, 3'd4, 1'b0, 1'b0, 8'd1},
        '{4'd0,  1'b1, 8'd0,   1'b1, 1'b0, 1'b0, 6'd8,  32'd300,    3'd2, 1'b0, 1'b0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] timeout_cycles = 32'd0;
    logic        cs_n, eng_req, eng_op;
    logic [5:0]  eng_cmd;
    logic [31:0] eng_arg;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_r1 = 8'hFF;
    logic [31:0] eng_resp = 32'd0;
    logic        busy, ready, block_addr;
    logic [2:0]  fail_code;

    always #10 clk = ~clk;

    sd_spi_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_cycles(timeout_cycles),
        .cs_n(cs_n), .eng_req(eng_req), .eng_op(eng_op), .eng_cmd(eng_cmd),
        .eng_arg(eng_arg), .eng_done(eng_done), .eng_r1(eng_r1), .eng_resp(eng_resp),
        .busy(busy), .ready(ready), .block_addr(block_addr), .fail_code(fail_code)
    );

    int   checks = 0;
    int   errors = 0;
    vec_t sc;
    int   n0, n41, ops, pend;
    int   viol_r1, viol_r8, viol_r10, viol_arg;
    logic prev_cs, prev_req;
    logic [7:0]  p_r1;
    logic [31:0] p_resp;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural command engine and protocol monitor (latency 3 cycles)
    initial begin
        sc = VECS[0];
        n0 = 0; n41 = 0; ops = 0; pend = 0;
        viol_r1 = 0; viol_r8 = 0; viol_r10 = 0; viol_arg = 0;
        prev_cs = 1'b1; prev_req = 1'b0; p_r1 = 8'hFF; p_resp = 32'd0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (start) begin
                n0 = 0; n41 = 0; ops = 0; pend = 0;
                viol_r1 = 0; viol_r8 = 0; viol_r10 = 0; viol_arg = 0;
            end
            if (pend != 0) begin
                pend--;
                if (pend == 0) begin
                    eng_done = 1'b1;
                    eng_r1   = p_r1;
                    eng_resp = p_resp;
                end
            end
            if (eng_req && prev_req) viol_r10++;
            if (eng_req) begin
                // R1: wake-up clocks first, then the reset command
                if (ops == 0 && !(eng_op && eng_arg == 32'd80 && eng_arg >= 32'd74 && cs_n)) viol_r1++;
                if (ops == 1 && !(!eng_op && eng_cmd == 6'd0)) viol_r1++;
                ops++;
                p_resp = 32'd0;
                p_r1   = 8'hFF;
                if (eng_op) begin
                    pend = 2;
                end else begin
                    // R8: selection rules around each command
                    if (cs_n) viol_r8++;
                    if (eng_cmd inside {6'd0, 6'd8, 6'd58, 6'd16} && !prev_cs) viol_r8++;
                    if (eng_cmd inside {6'd55, 6'd41} && prev_cs) viol_r8++;
                    case (eng_cmd)
                        6'd0: begin
                            if (eng_arg != 32'd0) viol_arg++;
                            p_r1 = (sc.bad0 == 4'd15 || n0 < int'(sc.bad0)) ? 8'hFF : 8'h01;
                            n0++;
                        end
                        6'd8: begin
                            if (eng_arg != 32'h1AA) viol_arg++;
                            p_r1   = 8'h01;
                            p_resp = sc.echo_ok ? 32'h0000_01AA : 32'h0000_00AA;
                        end
                        6'd55: begin
                            if (eng_arg != 32'd0) viol_arg++;
                            p_r1 = 8'h01;
                        end
                        6'd41: begin
                            if (eng_arg != 32'h4000_0000) viol_arg++;
                            p_r1 = (sc.busy41 == 8'd255 || n41 < int'(sc.busy41)) ? 8'h01 : 8'h00;
                            n41++;
                        end
                        6'd58: begin
                            if (eng_arg != 32'd0) viol_arg++;
                            p_r1   = sc.bad58 ? 8'h05 : 8'h00;
                            p_resp = sc.ccs ? 32'hC0FF_8000 : 32'h80FF_8000;
                        end
                        6'd16: begin
                            if (eng_arg != 32'h200) viol_arg++;
                            p_r1 = sc.bad16 ? 8'h04 : 8'h00;
                        end
                        default: viol_arg++;
                    endcase
                    pend = (eng_cmd == sc.stall) ? 0 : 2;
                end
            end
            prev_cs  = cs_n;
            prev_req = eng_req;
        end
    end

    task automatic launch(input logic [31:0] tmo, output int cyc);
        timeout_cycles = tmo;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk("R9", "ready while busy", ready, 0);
        chk("R9", "fail_code while busy", fail_code, 0);
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset ready", ready, 0);
        chk("R9", "reset fail_code", fail_code, 0);
        chk("R9", "reset busy", busy, 0);
        chk("R9", "reset cs_n", cs_n, 1);
        chk("R9", "reset eng_req", eng_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            sc = VECS[i];
            launch(VECS[i].tmo, cyc);
            $display("vector %0d ended after %0d cycles", i, cyc);
            chk("R2-R7", "fail_code", fail_code, VECS[i].e_fail);
            chk("R6", "ready", ready, VECS[i].e_ready);
            chk("R5", "block_addr", block_addr, VECS[i].e_blk);
            chk("R2", "reset command count", n0, VECS[i].e_cmd0);
            chk("R1", "wake-up order violations", viol_r1, 0);
            chk("R8", "chip select violations", viol_r8, 0);
            chk("R10", "request pulse violations", viol_r10, 0);
            chk("R3", "argument violations (R4 R6)", viol_arg, 0);
            if (i == 3) chk("R2", "fast no-card abort", (cyc < 300) ? 1 : 0, 1);
            repeat (4) @(negedge clk);
        end

        // R7: exact expiry point, reset phase never answered
        sc = VECS[0];
        sc.stall = 6'd0;
        launch(32'd50, cyc);
        chk("R7", "expiry cycle", cyc, 52);
        chk("R7", "expiry code in reset phase", fail_code, 1);
        repeat (4) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule